// File: doc/BRIEF.md
# Offset Modulo-9 Counter with Terminal Reload

This block is a 4-bit synchronous up-counter that runs over a shifted window of values instead of starting from zero. It counts 0010, 0011, ... up to 1010 and then returns to 0010, so it has nine states. The wrap does not come from the register overflowing. A detector watches the count for its terminal pattern, and when the detector is high the next rising edge loads a fixed start value in place of the increment.

The detector does not compare all four bits. It ANDs only the bits that are 1 in the terminal value, which for 1010 are bit 3 and bit 1. That is enough, because no earlier state in the window has both of those bits set. The start value and the terminal value are parameters.

An active-low clear presets the counter to the start value, so the sequence always begins inside the window. A count-enable input gates the increment. It does not gate the reload.

Top module: `offset_mod_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `count` becomes 0010 after that edge, whatever the values of `cnt_en` and `term_hit`.
- R2: `term_hit` is 1 exactly when bit 3 and bit 1 of `count` are both 1. Inside the window 0010 to 1010, this happens only at 1010.
- R3: When `term_hit` is 1 and `clr_n` is high at a rising edge, `count` becomes 0010 after that edge, whether `cnt_en` is 1 or 0.
- R4: When `term_hit` is 0, `cnt_en` is 1 and `clr_n` is high at a rising edge, `count` goes up by one. Bit 3 of `count` is the MSB and bit 0 is the LSB.
- R5: When `term_hit` is 0, `cnt_en` is 0 and `clr_n` is high at a rising edge, `count` keeps its value.
- R6: With `cnt_en` held at 1, the value 0010 comes back exactly every 9 clocks. The full sequence is 0010 through 1010 and then 0010 again.
- R7: After the first clear, `count` never takes a value below 0010 or above 1010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous active-low clear; presets the count to the start value |
| cnt_en | input | 1 | Count enable; gates the increment only |
| count | output | 4 | Current count, bit 3 is the MSB |
| term_hit | output | 1 | Terminal pattern detected; forces a reload on the next edge |

## Verification
The bench first holds the enable high for a long run. This shows the nine-step period and the single reload point, and it would reveal a detector that fires early or a counter that rolls over at sixteen. An irregular enable pattern follows, then a hold inserted at every state. Together these separate holding from counting, and they show that the reload at 1010 still happens with the enable low. Last, a clear is applied in every state of the window, with the enable high, to show that the clear overrides both the increment and the reload.

// File: rtl/ocnt_pkg.sv
// Package: ocnt_pkg
// Purpose: types shared by the offset counter blocks.
// Assumes: nothing beyond IEEE 1800-2017.
package ocnt_pkg;

    // Register update selected for the next clock edge, listed from highest to lowest priority.
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_INC   = 2'd2,
        ACT_HOLD  = 2'd3
    } ocnt_act_e;

endpackage

// File: rtl/ocnt_detect.sv
// Module: ocnt_detect
// Purpose: raises hit when every bit that is set in MASK is also set in value.
// Assumes: no state inside the counting window before the terminal value
//          contains all of the MASK bits, so a partial match is sufficient.
module ocnt_detect #(
    parameter int          WIDTH = 4,
    parameter logic [WIDTH-1:0] MASK = 4'b1010
) (
    input  logic [WIDTH-1:0] value,
    output logic             hit
);

    logic [WIDTH-1:0] bit_ok;

    // Per bit: a bit that is set in the mask must be 1; any other bit is a don't-care.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        if (MASK[gi]) begin : g_used
            assign bit_ok[gi] = value[gi];
        end else begin : g_free
            assign bit_ok[gi] = 1'b1;
        end
    end

    // Combine all per-bit results into a single AND.
    assign hit = &bit_ok;

endmodule

// File: rtl/ocnt_ctrl.sv
// Module: ocnt_ctrl
// Purpose: picks the register action from clear, detect and enable.
// Assumes: priority is clear, then reload, then count; the reload does not
//          depend on the enable.
module ocnt_ctrl
    import ocnt_pkg::*;
(
    input  logic      clr_n,
    input  logic      term,
    input  logic      en,
    output ocnt_act_e act
);

    // Apply the fixed priority order.
    always_comb begin
        if (!clr_n)    act = ACT_CLEAR;
        else if (term) act = ACT_LOAD;
        else if (en)   act = ACT_INC;
        else           act = ACT_HOLD;
    end

endmodule

// File: rtl/ocnt_reg.sv
// Module: ocnt_reg
// Purpose: count register that clears, loads, increments or holds as told.
// Assumes: a clear and a load both write the same start value.
module ocnt_reg
    import ocnt_pkg::*;
#(
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] START_VAL = 4'b0010
) (
    input  logic             clk,
    input  ocnt_act_e        act,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    // Work out the next register value from the selected action.
    always_comb begin
        unique case (act)
            ACT_CLEAR: q_next = START_VAL;
            ACT_LOAD:  q_next = START_VAL;
            ACT_INC:   q_next = q + ONE;
            default:   q_next = q;
        endcase
    end

    // Update the register on each rising edge.
    always_ff @(posedge clk) begin
        q <= q_next;
    end

endmodule

// File: rtl/offset_mod_counter.sv
// Module: offset_mod_counter
// Purpose: up-counter that runs from START_VAL to TERM_VAL and reloads
//          START_VAL on the edge after the terminal pattern is detected.
// Assumes: START_VAL < TERM_VAL, and no value in between holds every bit that
//          is set in TERM_VAL. clr_n is a synchronous active-low clear.
module offset_mod_counter #(
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] START_VAL = 4'b0010,
    parameter logic [WIDTH-1:0] TERM_VAL  = 4'b1010
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             cnt_en,
    output logic [WIDTH-1:0] count,
    output logic             term_hit
);

    import ocnt_pkg::*;

    localparam logic [WIDTH-1:0] DET_MASK = TERM_VAL;

    ocnt_act_e act;

    ocnt_detect #(
        .WIDTH (WIDTH),
        .MASK  (DET_MASK)
    ) i_detect (
        .value (count),
        .hit   (term_hit)
    );

    ocnt_ctrl i_ctrl (
        .clr_n (clr_n),
        .term  (term_hit),
        .en    (cnt_en),
        .act   (act)
    );

    ocnt_reg #(
        .WIDTH     (WIDTH),
        .START_VAL (START_VAL)
    ) i_reg (
        .clk (clk),
        .act (act),
        .q   (count)
    );

endmodule

// File: rtl/ocnt_checker.sv
// Module: ocnt_checker
// Purpose: protocol and sequence properties for offset_mod_counter, bound
//          to every instance of that module.
// Assumes: properties are only meaningful once a clear has been seen.
module ocnt_checker #(
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] START_VAL = 4'b0010,
    parameter logic [WIDTH-1:0] TERM_VAL  = 4'b1010
) (
    input logic             clk,
    input logic             clr_n,
    input logic             cnt_en,
    input logic [WIDTH-1:0] count,
    input logic             term_hit
);

    logic seen_clr = 1'b0;
    logic armed    = 1'b0;

    // Record that a clear has happened, and open checking one cycle later.
    always_ff @(posedge clk) begin
        if (!clr_n) seen_clr <= 1'b1;
        armed <= seen_clr || !clr_n;
    end

    p_clear_preset_r1: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> count == START_VAL);

    p_detect_only_term_r2: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        term_hit |-> count == TERM_VAL);

    p_term_flags_r2: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        count == TERM_VAL |-> term_hit);

    p_reload_r3: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && term_hit) |=> count == START_VAL);

    p_increment_r4: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !term_hit && cnt_en) |=> count == $past(count) + WIDTH'(1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !term_hit && !cnt_en) |=> $stable(count));

    p_in_window_r7: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        count >= START_VAL && count <= TERM_VAL);

endmodule

bind offset_mod_counter ocnt_checker #(
    .WIDTH     (WIDTH),
    .START_VAL (START_VAL),
    .TERM_VAL  (TERM_VAL)
) i_ocnt_checker (
    .clk      (clk),
    .clr_n    (clr_n),
    .cnt_en   (cnt_en),
    .count    (count),
    .term_hit (term_hit)
);

// File: tb/test_offset_mod_counter.sv
// Bench: test_offset_mod_counter
// Purpose: sweeps the counter through runs, enable patterns, holds and
//          clears, and compares every cycle with an arithmetic model.
module test_offset_mod_counter;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [3:0] count;
    logic       term_hit;

    int tests = 0;
    int fails = 0;
    int exp_cnt = 2;
    bit done = 1'b0;

    offset_mod_counter i_offset_mod_counter (
        .clk      (clk),
        .clr_n    (clr_n),
        .cnt_en   (cnt_en),
        .count    (count),
        .term_hit (term_hit)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Compare one value and log a failure line.
    task automatic check(input string req, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Drive one cycle of inputs, advance the model, and check the outputs.
    task automatic step(input bit c, input bit e, input string req);
        int prev;
        @(negedge clk);
        prev = exp_cnt;
        clr_n  = c;
        cnt_en = e;
        if (!c)               exp_cnt = 2;
        else if (prev == 10)  exp_cnt = 2;
        else if (e)           exp_cnt = prev + 1;
        @(posedge clk);
        #1;
        check(req, int'(count), exp_cnt);
        check("R2", int'(term_hit), (exp_cnt == 10) ? 1 : 0);
        tests++;
        if (int'(count) < 2 || int'(count) > 10) begin
            fails++;
            $display("FAIL R7: actual %0d expected 2..10", count);
        end
    endtask

    // Pick the requirement tag that describes the model transition.
    function automatic string tag_for(input bit c, input bit e, input int cur);
        if (!c)        return "R1";
        if (cur == 10) return "R3";
        if (e)         return "R4";
        return "R5";
    endfunction

    initial begin
        int last_start;
        // Reset state.
        repeat (3) step(1'b0, 1'b1, "R1");
        check("R1", int'(count), 2);
        check("R2", int'(term_hit), 0);

        // Continuous enable: 0010 must recur exactly every 9 clocks.
        last_start = 0;
        for (int i = 1; i <= 45; i++) begin
            step(1'b1, 1'b1, tag_for(1'b1, 1'b1, exp_cnt));
            if (count == 4'b0010) begin
                check("R6", i - last_start, 9);
                last_start = i;
            end
        end

        // Irregular enable pattern.
        for (int i = 0; i < 60; i++) begin
            bit e = (i % 3 != 0) && (i % 7 != 5);
            step(1'b1, e, tag_for(1'b1, e, exp_cnt));
        end

        // A hold inserted in each state; at 1010 the reload must still occur.
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0, tag_for(1'b1, 1'b0, exp_cnt));
            step(1'b1, 1'b1, tag_for(1'b1, 1'b1, exp_cnt));
        end

        // Clear applied in every state of the window with the enable high.
        for (int st = 2; st <= 10; st++) begin
            while (exp_cnt != st) step(1'b1, 1'b1, tag_for(1'b1, 1'b1, exp_cnt));
            step(1'b0, 1'b1, "R1");
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog: count an expired run as a failure.
    initial begin
        #200_000;
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule